// File: doc/BRIEF.md
# Boundary-Checked Serial Word Receiver

This block turns a one-bit serial stream into 22-bit parallel words. A frame is 25 bit times long. It starts with a lead bit that is always 0. The 22 data bits follow, least significant first. The frame ends with two trailing check bits, and each of them must be the complement of the last data bit (data bit 21). A bit clock is supplied, and the block takes exactly one line bit on every rising edge of `clk`.

The receiver begins without alignment. It looks at the line one bit position at a time for a 25-bit window that has the frame's shape. When it finds one, it follows that offset and declares lock only after a set number of consecutive frames have passed. While locked, it checks every frame and hands out each data word with a one-cycle strobe. The strobe stands in for the recovered parallel clock.

A framing error while locked starts a handshake with the transmitter. The receiver raises its line pull-up flag and goes quiet. It waits for the transmitter to power down, which shows as a run of low bits on the line. It then releases the flag and acquires alignment again. An active-low power-down input turns the receiver off and disables the handshake.

Top module: `serial_word_rx`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `word_stb`, `locked` and `line_pullup` are 0 and `dout` is all zeros.
- R2: A frame is: a lead bit of 0, then data bits 0 to 21 (bit 0 first), then two check bits that each equal the inverse of data bit 21. On a strobe, `dout[i]` equals the i-th bit that followed the lead bit of that frame.
- R3: `locked` rises on the cycle after the line has delivered `LOCK_FRAMES` (default 4) consecutive valid frames at one bit offset. It stays low before that.
- R4: `word_stb` is never high while the receiver is not locked. `dout` keeps its last delivered word whenever `word_stb` is low.
- R5: While locked, each valid frame produces exactly one single-cycle `word_stb`, one cycle after the frame's last check bit has been taken in.
- R6: A framing error seen while locked sets `line_pullup` to 1 and clears `locked` on the same cycle. No strobe is produced for the failing frame.
- R7: `line_pullup` stays 1 until the line has carried `IDLE_BITS` (default 8) consecutive 0 bits after the error. A 1 bit restarts that count. The flag then drops and acquisition restarts.
- R8: After the pull-up is released, valid frames are acquired again under R3, and word delivery resumes.
- R9: While `pwrdn_n` is 0, the receiver is off: `word_stb`, `locked` and `line_pullup` are 0, and line errors start no handshake. When `pwrdn_n` returns to 1, acquisition starts over.
- R10: Either of these, seen while locked, counts as a framing error: a lead bit of 1, or a single check bit that does not match the inverse of data bit 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one line bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sdi | input | 1 | Serial line bit |
| pwrdn_n | input | 1 | Active-low power-down; low turns the receiver off |
| dout | output | 22 | Last delivered data word |
| word_stb | output | 1 | One-cycle pulse marking a new word on `dout` |
| locked | output | 1 | High while word alignment is established |
| line_pullup | output | 1 | High while the receiver signals an error by pulling the line up |

## Verification
The stream is driven with several patterns. Repeated alternating-bit words from a clean start contain no false frame shapes, so they pin down the exact frame on which lock is declared. Distinct data words then confirm that bits come out least significant first. Corrupted frames separate the failure cases: a single wrong check bit, a lead bit of 1, and errors arriving while powered down, which must be ignored. Zero runs broken by a single 1 test that the release count restarts, while an unbroken run of zeros must release the flag. A behavioural model in the bench, built on a bit history, predicts all four outputs on every clock.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_HUNT,
    ST_TRACK,
    ST_LOCK,
    ST_PULL
  } rx_state_e;

endpackage

// File: rtl/rxw_frame_window.sv
module rxw_frame_window #(
  parameter int DATA_W = 22,
  parameter int NBOUND = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdi,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_ok,
  output logic              last_bit
);

  localparam int FRAME_W = 1 + DATA_W + NBOUND;

  // oldest bit sits at index 0 (lead position), newest at the top
  logic [FRAME_W-1:0] win;
  logic [NBOUND-1:0]  bnd_ok;

  always_ff @(posedge clk) begin
    if (rst) win <= '0;
    else     win <= {sdi, win[FRAME_W-1:1]};
  end

  for (genvar g = 0; g < NBOUND; g++) begin : g_bnd
    assign bnd_ok[g] = win[DATA_W+1+g] ^ win[DATA_W];
  end

  assign frame_ok = ~win[0] & (&bnd_ok);
  assign data_o   = win[DATA_W:1];
  assign last_bit = win[FRAME_W-1];

endmodule

// File: rtl/rxw_idle_timer.sv
module rxw_idle_timer #(
  parameter int IDLE_BITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic line_bit,
  output logic idle_done
);

  localparam int CW = $clog2(IDLE_BITS + 1);

  logic [CW-1:0] run_q;

  assign idle_done = active & ~line_bit & (run_q == CW'(IDLE_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst || !active)  run_q <= '0;
    else if (line_bit)   run_q <= '0;
    else if (!idle_done) run_q <= run_q + 1'b1;
  end

endmodule

// File: rtl/rxw_align_fsm.sv
module rxw_align_fsm
  import rxw_pkg::*;
#(
  parameter int FRAME_W     = 25,
  parameter int LOCK_FRAMES = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pwrdn_n,
  input  logic      frame_ok,
  input  logic      idle_done,
  output rx_state_e state,
  output logic      word_take
);

  localparam int PH_W  = $clog2(FRAME_W);
  localparam int CNT_W = $clog2(LOCK_FRAMES + 1);

  rx_state_e        st_n;
  logic [PH_W-1:0]  phase, ph_n;
  logic [CNT_W-1:0] lock_cnt, cnt_n;
  logic             frame_end;

  assign frame_end = (phase == PH_W'(FRAME_W - 1));
  assign word_take = pwrdn_n & (state == ST_LOCK) & frame_end & frame_ok;

  always_comb begin
    st_n  = state;
    ph_n  = phase;
    cnt_n = lock_cnt;
    if (!pwrdn_n) begin
      st_n  = ST_OFF;
      ph_n  = '0;
      cnt_n = '0;
    end else begin
      case (state)
        ST_OFF: st_n = ST_HUNT;
        ST_HUNT: begin
          if (frame_ok) begin
            ph_n = '0;
            if (LOCK_FRAMES <= 1) begin
              st_n = ST_LOCK;
            end else begin
              st_n  = ST_TRACK;
              cnt_n = CNT_W'(1);
            end
          end
        end
        ST_TRACK: begin
          if (frame_end) begin
            ph_n = '0;
            if (frame_ok) begin
              cnt_n = lock_cnt + 1'b1;
              if (lock_cnt == CNT_W'(LOCK_FRAMES - 1)) st_n = ST_LOCK;
            end else begin
              st_n = ST_HUNT;
            end
          end else begin
            ph_n = phase + 1'b1;
          end
        end
        ST_LOCK: begin
          if (frame_end) begin
            ph_n = '0;
            if (!frame_ok) st_n = ST_PULL;
          end else begin
            ph_n = phase + 1'b1;
          end
        end
        ST_PULL: if (idle_done) st_n = ST_HUNT;
        default: st_n = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HUNT;
      phase    <= '0;
      lock_cnt <= '0;
    end else begin
      state    <= st_n;
      phase    <= ph_n;
      lock_cnt <= cnt_n;
    end
  end

endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
  import rxw_pkg::*;
#(
  parameter int DATA_W      = 22,
  parameter int NBOUND      = 2,
  parameter int LOCK_FRAMES = 4,
  parameter int IDLE_BITS   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdi,
  input  logic              pwrdn_n,
  output logic [DATA_W-1:0] dout,
  output logic              word_stb,
  output logic              locked,
  output logic              line_pullup
);

  localparam int FRAME_W = 1 + DATA_W + NBOUND;

  logic [DATA_W-1:0] win_data;
  logic              frame_ok;
  logic              last_bit;
  logic              idle_done;
  logic              word_take;
  rx_state_e         state;

  rxw_frame_window #(.DATA_W(DATA_W), .NBOUND(NBOUND)) u_win (
    .clk      (clk),
    .rst      (rst),
    .sdi      (sdi),
    .data_o   (win_data),
    .frame_ok (frame_ok),
    .last_bit (last_bit)
  );

  rxw_align_fsm #(.FRAME_W(FRAME_W), .LOCK_FRAMES(LOCK_FRAMES)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .pwrdn_n   (pwrdn_n),
    .frame_ok  (frame_ok),
    .idle_done (idle_done),
    .state     (state),
    .word_take (word_take)
  );

  rxw_idle_timer #(.IDLE_BITS(IDLE_BITS)) u_idle (
    .clk       (clk),
    .rst       (rst),
    .active    (state == ST_PULL),
    .line_bit  (last_bit),
    .idle_done (idle_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      word_stb <= 1'b0;
    end else begin
      word_stb <= word_take;
      if (word_take) dout <= win_data;
    end
  end

  assign locked      = (state == ST_LOCK);
  assign line_pullup = (state == ST_PULL);

endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
  parameter int DATA_W    = 22,
  parameter int IDLE_BITS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sdi,
  input logic              pwrdn_n,
  input logic [DATA_W-1:0] dout,
  input logic              word_stb,
  input logic              locked,
  input logic              line_pullup
);

  localparam int ZW = $clog2(IDLE_BITS + 1);

  logic [ZW-1:0] zero_run;

  always_ff @(posedge clk) begin
    if (rst || sdi)                     zero_run <= '0;
    else if (zero_run < ZW'(IDLE_BITS)) zero_run <= zero_run + 1'b1;
  end

  assert_stb_needs_lock_R4: assert property (@(posedge clk) disable iff (rst)
    word_stb |-> locked);

  assert_dout_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !word_stb |-> $stable(dout));

  assert_stb_single_R5: assert property (@(posedge clk) disable iff (rst)
    word_stb |=> !word_stb);

  assert_pullup_from_lock_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(line_pullup) |-> ($past(locked) && !locked && !word_stb));

  assert_release_after_idle_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(line_pullup) && $past(pwrdn_n)) |-> ($past(zero_run) >= ZW'(IDLE_BITS)));

  assert_off_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !pwrdn_n |=> (!line_pullup && !word_stb && !locked));

endmodule

bind serial_word_rx rxw_checker #(.DATA_W(DATA_W), .IDLE_BITS(IDLE_BITS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sdi         (sdi),
  .pwrdn_n     (pwrdn_n),
  .dout        (dout),
  .word_stb    (word_stb),
  .locked      (locked),
  .line_pullup (line_pullup)
);

// File: tb/serial_word_rx_tb.sv
module serial_word_rx_tb;

  localparam int DW    = 22;
  localparam int LOCKN = 4;
  localparam int IDLEN = 8;
  localparam int FW    = 1 + DW + 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sdi = 1'b0;
  logic          pwrdn_n = 1'b1;
  logic [DW-1:0] dout;
  logic          word_stb, locked, line_pullup;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  serial_word_rx #(.DATA_W(DW), .NBOUND(2), .LOCK_FRAMES(LOCKN), .IDLE_BITS(IDLEN)) u_dut (
    .clk(clk), .rst(rst), .sdi(sdi), .pwrdn_n(pwrdn_n),
    .dout(dout), .word_stb(word_stb), .locked(locked), .line_pullup(line_pullup)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit            hist[$];
  int            m_st;  // 0 off, 1 hunt, 2 track, 3 lock, 4 pull-up
  int            m_cnt, m_ph, m_idle;
  logic [DW-1:0] m_dout;
  bit            m_stb, m_lock, m_pull;
  bit            model_on = 0;

  function automatic bit hist_frame_ok();
    int h = hist.size();
    bit d21 = hist[h-3];
    return (hist[h-FW] == 1'b0) && (hist[h-2] != d21) && (hist[h-1] != d21);
  endfunction

  function automatic logic [DW-1:0] hist_word();
    logic [DW-1:0] w;
    int h = hist.size();
    for (int i = 0; i < DW; i++) w[i] = hist[h-FW+1+i];
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st = 1; m_cnt = 0; m_ph = 0; m_idle = 0;
      m_dout = '0; m_stb = 0; m_lock = 0; m_pull = 0;
      hist.delete();
      for (int i = 0; i < FW; i++) hist.push_back(1'b0);
      model_on = 1;
    end else begin
      bit ok;
      bit last;
      ok = hist_frame_ok();
      last = hist[hist.size()-1];
      m_stb = 0;
      if (!pwrdn_n) begin
        m_st = 0; m_ph = 0; m_cnt = 0; m_idle = 0; m_lock = 0; m_pull = 0;
      end else begin
        case (m_st)
          0: m_st = 1;
          1: if (ok) begin
               m_ph = 0; m_st = 2; m_cnt = 1;
             end
          2: if (m_ph == FW-1) begin
               m_ph = 0;
               if (ok) begin
                 m_cnt++;
                 if (m_cnt == LOCKN) begin m_st = 3; m_lock = 1; end
               end else m_st = 1;
             end else m_ph++;
          3: if (m_ph == FW-1) begin
               m_ph = 0;
               if (ok) begin m_dout = hist_word(); m_stb = 1; end
               else begin m_st = 4; m_lock = 0; m_pull = 1; m_idle = 0; end
             end else m_ph++;
          default: if (!last) begin
               if (m_idle == IDLEN-1) begin m_st = 1; m_pull = 0; m_idle = 0; end
               else m_idle++;
             end else m_idle = 0;
        endcase
      end
      hist.push_back(sdi);
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check("R5 word_stb vs model", {31'd0, word_stb}, {31'd0, m_stb});
      check("R2 dout vs model", {10'd0, dout}, {10'd0, m_dout});
      check("R3 locked vs model", {31'd0, locked}, {31'd0, m_lock});
      check("R6 line_pullup vs model", {31'd0, line_pullup}, {31'd0, m_pull});
    end
  end

  // ---------------- stimulus ----------------
  logic          s_lock, s_stb, s_pull;
  logic [DW-1:0] s_dout;

  task automatic send_bits(input logic b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sdi = b;
    end
  endtask

  // mode 0 good, 1 second check bit wrong, 2 lead bit set
  task automatic send_frame(input logic [DW-1:0] d, input int mode);
    for (int i = 0; i < FW; i++) begin
      logic b;
      if (i == 0)        b = (mode == 2);
      else if (i <= DW)  b = d[i-1];
      else if (i == DW+1) b = ~d[DW-1];
      else               b = (mode == 1) ? d[DW-1] : ~d[DW-1];
      @(negedge clk);
      sdi = b;
      if (i == 1) begin
        // outputs here reflect the decision on the previous frame
        s_lock = locked; s_stb = word_stb; s_pull = line_pullup; s_dout = dout;
      end
    end
  endtask

  localparam logic [DW-1:0] ALT = 22'h155555;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 stb in reset", {31'd0, word_stb}, 32'd0);
    check("R1 dout in reset", {10'd0, dout}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    check("R1 locked after reset", {31'd0, locked}, 32'd0);
    check("R1 pullup after reset", {31'd0, line_pullup}, 32'd0);

    // acquisition from a clean start
    send_frame(ALT, 0);
    send_frame(ALT, 0);
    send_frame(ALT, 0);
    check("R3 not locked before 4th frame", {31'd0, s_lock}, 32'd0);
    send_frame(ALT, 0);
    check("R4 no strobe while acquiring", {31'd0, s_stb}, 32'd0);
    send_frame(22'h0ABCDE, 0);
    check("R3 locked after 4 frames", {31'd0, s_lock}, 32'd1);
    check("R4 no strobe on lock frame", {31'd0, s_stb}, 32'd0);
    send_frame(22'h3C0F0F, 0);
    check("R5 strobe for first locked frame", {31'd0, s_stb}, 32'd1);
    check("R2 LSB-first word", {10'd0, s_dout}, 32'h0ABCDE);
    send_frame(22'h2AAAAA, 1);
    check("R2 second word", {10'd0, s_dout}, 32'h3C0F0F);

    // single wrong check bit while locked
    send_bits(1'b0, 3);
    check("R10 one bad check bit raises pullup", {31'd0, line_pullup}, 32'd1);
    check("R6 lock dropped on error", {31'd0, locked}, 32'd0);
    check("R4 dout held after error", {10'd0, dout}, 32'h3C0F0F);
    send_bits(1'b1, 1);
    send_bits(1'b0, 7);
    check("R7 broken zero run keeps pullup", {31'd0, line_pullup}, 32'd1);
    send_bits(1'b0, 3);
    check("R7 pullup released after idle run", {31'd0, line_pullup}, 32'd0);

    // re-acquisition
    for (int k = 0; k < LOCKN; k++) send_frame(ALT, 0);
    send_frame(22'h123456, 0);
    check("R8 relocked after release", {31'd0, s_lock}, 32'd1);
    send_frame(ALT, 0);
    check("R8 words resume", {10'd0, s_dout}, 32'h123456);
    check("R8 strobe resumes", {31'd0, s_stb}, 32'd1);

    // lead bit error while locked
    send_frame(22'h00FF00, 2);
    send_bits(1'b0, 3);
    check("R10 lead bit set raises pullup", {31'd0, line_pullup}, 32'd1);
    send_bits(1'b0, 10);
    check("R7 release after lead error", {31'd0, line_pullup}, 32'd0);

    // powered down: errors are ignored
    for (int k = 0; k < LOCKN + 1; k++) send_frame(ALT, 0);
    check("R9 locked before power-down", {31'd0, s_lock}, 32'd1);
    pwrdn_n = 1'b0;
    send_frame(22'h3FFFFF, 1);
    send_frame(22'h111111, 2);
    send_bits(1'b1, 5);
    check("R9 no pullup while off", {31'd0, line_pullup}, 32'd0);
    check("R9 not locked while off", {31'd0, locked}, 32'd0);
    check("R9 no strobe while off", {31'd0, word_stb}, 32'd0);
    send_bits(1'b0, 5);
    pwrdn_n = 1'b1;
    for (int k = 0; k < LOCKN; k++) send_frame(ALT, 0);
    send_frame(22'h2468AC, 0);
    send_frame(ALT, 0);
    check("R9 restart after power-up", {10'd0, s_dout}, 32'h2468AC);
    send_bits(1'b0, 4);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule